// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog and periodic timer that sits on a simple 32-bit register bus. A 31-bit up-counter advances on each cycle in which the `tick_i` enable is high. Depending on the run mode, it advances on every tick or only while the processor is awake. A 16-bit window of the counter is taken at a programmable shift and compared against a compare value. When the window reaches the compare value, the block raises a one-cycle reset request or, in periodic mode, sets a sticky interrupt flag and restarts the count.

Writes to the control, compare and feed registers are guarded. Software must first write a key word, and the next write consumes the unlock, whether it lands or not. The running watchdog is restarted by an unlocked write of a magic word to the feed register. The count and the pending flag stay writable without the key, so a service routine can clear the interrupt quickly.

Register word addresses: 0 control, 1 count, 2 scaled view (read-only), 3 feed, 4 key, 5 compare, 6 pending. Control bits: [3:0] shift, [4] reset enable, [5] zero-on-compare, [6] run always, [7] run only while awake. Reads of feed, key and unused addresses return zero.

Top module: `wdt_keyed_top`

## Requirements
- R1: The count is 31 bits wide and is read and written at address 1 without the key. Bit 31 always reads as zero, and written values keep only bits [30:0].
- R2: On a cycle with `tick_i` high, the count rises by one if control bit 6 is set, or if control bit 7 is set and `asleep_i` is low. Otherwise it holds. It wraps from 0x7FFFFFFF to 0.
- R3: A write of 0x0051F15E to address 4 unlocks the block. Any other bus write, to any address, locks it again. Writes to control (0), feed (3) and compare (5) while locked change nothing.
- R4: An unlocked write of 0x0D09F00D to the feed register clears the count. Any other feed value, or a locked feed write, leaves the count unchanged.
- R5: The scaled view at address 2 equals count bits [s+15:s], where s is control[3:0], with zeros above bit 30.
- R6: The comparator fires while the scaled view is greater than or equal to compare[15:0]. Compare resets to 0xFFFF.
- R7: The pending flag (address 6 bit 0, also `irq_o`) is set in the cycle after the comparator fires and then stays set. A write with bit 0 clear clears it, and a write with bit 0 set has no effect. A firing comparator beats a clear in the same cycle.
- R8: With control bit 5 set, the count is cleared in the cycle after the comparator fires, with or without a tick. A bus write to the count or an accepted feed takes priority over this clear.
- R9: With control bit 4 set, `rst_req_o` is high for exactly one cycle in the cycle after the comparator starts to fire. With bit 4 clear, it stays low.
- R10: After reset the count, control and pending flag are zero, compare is 0xFFFF, the block is locked and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Count enable from the timer clock selection |
| asleep_i | input | 1 | High while the processor sleeps |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| rst_req_o | output | 1 | One-cycle reset request pulse |
| irq_o | output | 1 | Sticky interrupt pending |

## Verification
A software clear of the pending flag can arrive in the same cycle that the comparator fires. This is provoked by writing a count at or above the compare value and following it at once with a write of zero to the pending register. The flag must read back as set, and the same sequence with a count below the compare value must read back as clear. A second collision is between a bus write to the count and the zero-on-compare clear. Writing a count that fires the comparator must leave the count at zero one cycle later, with no tick running.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;
  localparam int SCALE_W = 4;

  localparam logic [DATA_W-1:0] UNLOCK_WORD = 32'h0051_F15E;
  localparam logic [DATA_W-1:0] FEED_WORD   = 32'h0D09_F00D;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL   = 3'd0,
    RA_COUNT  = 3'd1,
    RA_SCALED = 3'd2,
    RA_FEED   = 3'd3,
    RA_KEY    = 3'd4,
    RA_CMP    = 3'd5,
    RA_PEND   = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic               run_awake;
    logic               run_always;
    logic               zero_cmp;
    logic               rst_en;
    logic [SCALE_W-1:0] shift;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/wdt_regbank.sv
module wdt_regbank
  import wdt_pkg::*;
#(
  parameter int CMP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output ctrl_t             ctrl_o,
  output logic [CMP_W-1:0]  cmp_o,
  output logic              unlocked_o,
  output logic              feed_o,
  output logic              cnt_wr_o,
  output logic              pend_clr_o
);

  ctrl_t             ctrl_q, ctrl_d;
  logic [CMP_W-1:0]  cmp_q, cmp_d;
  logic              unlk_q, unlk_d;
  logic              ctrl_en, cmp_en, unlk_en;
  logic              hit_ctrl, hit_cmp, hit_feed, hit_key;

  assign hit_ctrl = (reg_addr == RA_CTRL);
  assign hit_cmp  = (reg_addr == RA_CMP);
  assign hit_feed = (reg_addr == RA_FEED);
  assign hit_key  = (reg_addr == RA_KEY);

  // Next-state logic
  always_comb begin
    ctrl_d  = ctrl_t'(reg_wdata[CTRL_W-1:0]);
    cmp_d   = reg_wdata[CMP_W-1:0];
    unlk_d  = hit_key && (reg_wdata == UNLOCK_WORD);
    ctrl_en = reg_wr && unlk_q && hit_ctrl;
    cmp_en  = reg_wr && unlk_q && hit_cmp;
    unlk_en = reg_wr;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '1;
    end else if (cmp_en) begin
      cmp_q <= cmp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlk_q <= 1'b0;
    end else if (unlk_en) begin
      unlk_q <= unlk_d;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign cmp_o      = cmp_q;
  assign unlocked_o = unlk_q;
  assign feed_o     = reg_wr && unlk_q && hit_feed && (reg_wdata == FEED_WORD);
  assign cnt_wr_o   = reg_wr && (reg_addr == RA_COUNT);
  assign pend_clr_o = reg_wr && (reg_addr == RA_PEND) && !reg_wdata[0];

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             feed_i,
  input  logic             zero_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // Priority: bus write, feed, zero-on-compare, increment
  always_comb begin
    cnt_en = wr_i || feed_i || zero_i || inc_i;
    if (wr_i) begin
      cnt_d = wdata_i;
    end else if (feed_i || zero_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/wdt_compare.sv
module wdt_compare #(
  parameter int CNT_W   = 31,
  parameter int CMP_W   = 16,
  parameter int SCALE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [SCALE_W-1:0] shift_i,
  input  logic [CMP_W-1:0]   cmp_i,
  input  logic               rst_en_i,
  input  logic               pend_clr_i,
  output logic [CMP_W-1:0]   scaled_o,
  output logic               hit_o,
  output logic               pend_o,
  output logic               rst_req_o
);

  localparam int NSHIFT = 1 << SCALE_W;

  logic [CMP_W-1:0] win [NSHIFT];

  for (genvar s = 0; s < NSHIFT; s++) begin : g_win
    if (s + CMP_W <= CNT_W) begin : g_full
      assign win[s] = cnt_i[s +: CMP_W];
    end else begin : g_part
      assign win[s] = CMP_W'(cnt_i >> s);
    end
  end

  logic pend_q, pend_d;
  logic fire_q, fire_d;
  logic req_q, req_d;
  logic pend_en;

  always_comb begin
    scaled_o = win[shift_i];
    hit_o    = (scaled_o >= cmp_i);
    pend_en  = hit_o || pend_clr_i;
    pend_d   = hit_o;
    fire_d   = hit_o && rst_en_i;
    req_d    = fire_d && !fire_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      fire_q <= fire_d;
      req_q  <= req_d;
    end
  end

  assign pend_o    = pend_q;
  assign rst_req_o = req_q;

endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
  import wdt_pkg::*;
#(
  parameter int CNT_W = 31,
  parameter int CMP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              asleep_i,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              rst_req_o,
  output logic              irq_o
);

  logic             rst_sync_n;
  ctrl_t            ctrl;
  logic [CMP_W-1:0] cmp;
  logic             unlocked;
  logic             feed, cnt_wr, pend_clr;
  logic [CNT_W-1:0] cnt;
  logic [CMP_W-1:0] scaled;
  logic             hit, pend, inc_en, zero_req;

  wdt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wdt_regbank #(.CMP_W(CMP_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .ctrl_o     (ctrl),
    .cmp_o      (cmp),
    .unlocked_o (unlocked),
    .feed_o     (feed),
    .cnt_wr_o   (cnt_wr),
    .pend_clr_o (pend_clr)
  );

  assign inc_en   = tick_i && (ctrl.run_always || (ctrl.run_awake && !asleep_i));
  assign zero_req = ctrl.zero_cmp && hit;

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_i    (cnt_wr),
    .wdata_i (reg_wdata[CNT_W-1:0]),
    .feed_i  (feed),
    .zero_i  (zero_req),
    .inc_i   (inc_en),
    .cnt_o   (cnt)
  );

  wdt_compare #(.CNT_W(CNT_W), .CMP_W(CMP_W), .SCALE_W(SCALE_W)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cnt_i      (cnt),
    .shift_i    (ctrl.shift),
    .cmp_i      (cmp),
    .rst_en_i   (ctrl.rst_en),
    .pend_clr_i (pend_clr),
    .scaled_o   (scaled),
    .hit_o      (hit),
    .pend_o     (pend),
    .rst_req_o  (rst_req_o)
  );

  assign irq_o = pend;

  always_comb begin
    case (reg_addr)
      RA_CTRL:   reg_rdata = DATA_W'(ctrl);
      RA_COUNT:  reg_rdata = DATA_W'(cnt);
      RA_SCALED: reg_rdata = DATA_W'(scaled);
      RA_CMP:    reg_rdata = DATA_W'(cmp);
      RA_PEND:   reg_rdata = DATA_W'(pend);
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int CNT_W  = 31,
  parameter int CTRL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              asleep_i,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              rst_req_o,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt,
  input logic [CTRL_W-1:0] ctrl_bits,
  input logic              hit,
  input logic              unlocked
);

  logic run_ok, zeroing;
  assign run_ok  = tick_i && (ctrl_bits[6] || (ctrl_bits[7] && !asleep_i));
  assign zeroing = ctrl_bits[5] && hit;

  p_bit31_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd1) |-> !reg_rdata[31]);

  p_incr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && run_ok && !zeroing) |=> (cnt == $past(cnt) + 31'd1));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !run_ok && !zeroing) |=> $stable(cnt));

  p_locked_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && !unlocked) |=> $stable(ctrl_bits));

  p_pend_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> irq_o);

  p_pend_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(reg_wr && reg_addr == 3'd6 && !reg_wdata[0])) |=> irq_o);

  p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && zeroing) |=> (cnt == '0));

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  p_req_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> $past(hit && ctrl_bits[4]));

endmodule

bind wdt_keyed_top wdt_keyed_chk #(.CNT_W(CNT_W), .CTRL_W(wdt_pkg::CTRL_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .tick_i    (tick_i),
  .asleep_i  (asleep_i),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .rst_req_o (rst_req_o),
  .irq_o     (irq_o),
  .cnt       (cnt),
  .ctrl_bits (ctrl),
  .hit       (hit),
  .unlocked  (unlocked)
);

// File: tb/wdt_keyed_top_tb_top.sv
`timescale 1ns/1ps
module wdt_keyed_top_tb_top;

  localparam logic [2:0] A_CTRL = 3'd0, A_CNT = 3'd1, A_SCL = 3'd2, A_FEED = 3'd3,
                         A_KEY = 3'd4, A_CMP = 3'd5, A_PEND = 3'd6;
  localparam logic [31:0] KEYW = 32'h0051_F15E, FEEDW = 32'h0D09_F00D;

  typedef struct packed {
    logic [3:0]  sh;
    logic [31:0] cnt;
    logic [15:0] cmp;
    logic [15:0] exp_scl;
    logic        exp_hit;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'd0,  32'h0000_1234, 16'h1234, 16'h1234, 1'b1},
    '{4'd0,  32'h0000_1233, 16'h1234, 16'h1233, 1'b0},
    '{4'd4,  32'h0001_2345, 16'h1234, 16'h1234, 1'b1},
    '{4'd15, 32'h7FFF_8000, 16'hFFFF, 16'hFFFF, 1'b1},
    '{4'd8,  32'h00AB_CDEF, 16'hABCE, 16'hABCD, 1'b0},
    '{4'd0,  32'h0001_0005, 16'h0006, 16'h0005, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        asleep_i = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        rst_req_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdt_keyed_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .asleep_i(asleep_i),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rst_req_o(rst_req_o), .irq_o(irq_o)
  );

  always @(negedge clk) if (rst_req_o) pulses++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic uwr(input logic [2:0] a, input logic [31:0] d);
    wr(A_KEY, KEYW);
    wr(a, d);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    rd(A_CTRL, v); check("R10 ctrl", v, 32'h0);
    rd(A_CNT, v);  check("R10 count", v, 32'h0);
    rd(A_CMP, v);  check("R10 cmp", v, 32'h0000_FFFF);
    rd(A_PEND, v); check("R10 pend", v, 32'h0);
    check("R10 rst_req", {31'd0, rst_req_o}, 32'h0);
    check("R10 irq", {31'd0, irq_o}, 32'h0);
    wr(A_CTRL, 32'h1F);
    rd(A_CTRL, v); check("R10 locked after reset", v, 32'h0);

    // R5 R6 R7 vector table
    foreach (VECS[i]) begin
      uwr(A_CTRL, {28'd0, VECS[i].sh});
      uwr(A_CMP, {16'd0, VECS[i].cmp});
      wr(A_CNT, VECS[i].cnt);
      wr(A_PEND, 32'h0);
      rd(A_SCL, v);  check("R5 scaled view", v, {16'd0, VECS[i].exp_scl});
      rd(A_PEND, v); check("R6 R7 compare and pend", v, {31'd0, VECS[i].exp_hit});
    end

    // R1 bit 31
    uwr(A_CTRL, 32'h0);
    wr(A_CNT, 32'hFFFF_FFFF);
    rd(A_CNT, v); check("R1 bit31 reads zero", v, 32'h7FFF_FFFF);

    // R2 gating
    uwr(A_CTRL, 32'h80);
    wr(A_CNT, 32'd100);
    asleep_i = 1'b1; ticks(10);
    rd(A_CNT, v); check("R2 awake-only held while asleep", v, 32'd100);
    asleep_i = 1'b0; ticks(10);
    rd(A_CNT, v); check("R2 awake-only counts", v, 32'd110);
    uwr(A_CTRL, 32'h40);
    asleep_i = 1'b1; ticks(7);
    rd(A_CNT, v); check("R2 always counts asleep", v, 32'd117);
    uwr(A_CTRL, 32'h0);
    ticks(5);
    rd(A_CNT, v); check("R2 stopped", v, 32'd117);
    asleep_i = 1'b0;
    uwr(A_CTRL, 32'h40);
    wr(A_CNT, 32'h7FFF_FFFF);
    ticks(1);
    rd(A_CNT, v); check("R2 wrap", v, 32'h0);

    // R3 key
    uwr(A_CTRL, 32'h03);
    rd(A_CTRL, v); check("R3 unlocked write", v, 32'h03);
    wr(A_CTRL, 32'h0F);
    rd(A_CTRL, v); check("R3 locked write ignored", v, 32'h03);
    wr(A_KEY, 32'h0051_F15F); wr(A_CTRL, 32'h0F);
    rd(A_CTRL, v); check("R3 wrong key", v, 32'h03);
    wr(A_KEY, KEYW); wr(A_CNT, 32'd5); wr(A_CTRL, 32'h0F);
    rd(A_CTRL, v); check("R3 relock by other write", v, 32'h03);
    rd(A_CMP, v); wr(A_CMP, 32'h1111);
    begin
      logic [31:0] v2;
      rd(A_CMP, v2); check("R3 cmp locked", v2, v);
    end

    // R4 feed
    uwr(A_CTRL, 32'h0);
    wr(A_CNT, 32'd500);
    uwr(A_FEED, FEEDW);
    rd(A_CNT, v); check("R4 feed clears", v, 32'h0);
    wr(A_CNT, 32'd500);
    uwr(A_FEED, 32'h1234_5678);
    rd(A_CNT, v); check("R4 wrong feed word", v, 32'd500);
    wr(A_FEED, FEEDW);
    rd(A_CNT, v); check("R4 locked feed", v, 32'd500);

    // R8 periodic mode
    uwr(A_CMP, 32'd4);
    uwr(A_CTRL, 32'h60);
    wr(A_CNT, 32'd0);
    wr(A_PEND, 32'h0);
    p0 = pulses;
    ticks(23);
    rd(A_CNT, v); check("R8 auto-zero period", v, 32'd3);
    check("R8 irq set", {31'd0, irq_o}, 32'h1);
    check("R9 no pulse when disabled", pulses - p0, 32'd0);
    wr(A_CNT, 32'd4);
    @(negedge clk);
    rd(A_CNT, v); check("R8 zero without tick", v, 32'h0);

    // R7 pend clear semantics
    wr(A_PEND, 32'h1);
    check("R7 write one no effect", {31'd0, irq_o}, 32'h1);
    wr(A_PEND, 32'h0);
    check("R7 write zero clears", {31'd0, irq_o}, 32'h0);

    // R9 reset requests
    uwr(A_CMP, 32'd3);
    uwr(A_CTRL, 32'h50);
    wr(A_CNT, 32'd0);
    p0 = pulses;
    ticks(10);
    check("R9 single pulse", pulses - p0, 32'd1);
    uwr(A_FEED, FEEDW);
    ticks(6);
    check("R9 pulse after feed", pulses - p0, 32'd2);
    check("R9 request low at rest", {31'd0, rst_req_o}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule